// File: doc/BRIEF.md
# Defect Recovery Dispatch Unit

This block is the chip-level collection point for defect-condition matches. Each neighborhood hub reports one match at a time. A report carries a condition index, a timing tag that says whether the condition was caught before the defect took effect or after it, and a reach tag that says how far the effects may have spread. The unit turns each report into exactly one recovery action and issues it as a single-cycle request strobe. It then holds the action index and source hub steady until the responder acknowledges.

Every hub has a one-entry holding slot, so a report that arrives while an action is in flight waits instead of being lost. When several slots are occupied, the unit picks the most severe pending action first, and the lowest hub index breaks ties. A flush or rollback that no one acknowledges within a bounded window is escalated to an operating-system interrupt for the same condition.

Top module: `recovery_dispatch`

## Requirements
- R1: A report with timing tag post (pre=0) and reach code 0 (pipeline only) produces a `flush_req` strobe.
- R2: A post report with reach code 1 (one module) produces a `rollback_req` strobe.
- R3: A post report with reach code 2 or 3 (beyond one module) produces an `osint_req` strobe.
- R4: A pre report (pre=1) with reach code 1 produces a `modrst_req` strobe. A pre report with any other reach code produces a `cond_off_req` strobe, which disables the condition and lets execution continue.
- R5: When several slots are pending, the unit picks by severity: OS interrupt, then rollback, then module reset, then flush, then condition-off. Among equal severities the lowest hub index goes first.
- R6: Each strobe is high for exactly one cycle, and at most one strobe is high in any cycle. `act_cond` and `act_hub` give the report's condition index and hub, and they stay steady until acknowledged.
- R7: After a strobe, `busy` stays high and no new action starts until `act_ack` is seen. The unit then returns to idle.
- R8: A report that arrives at a hub while its slot is empty is held (`hub_full` high) until it is dispatched. A report offered to a hub whose slot is already full is discarded, and the held one is kept.
- R9: A flush or rollback that is unacknowledged for TIMEOUT cycles after its strobe is re-issued as `osint_req` with the same condition and hub. A module reset or condition-off never escalates.
- R10: After reset, no strobe is high, `busy` is low and every slot is empty.
- R11: A report offered to an idle unit with no other slots pending is latched at the next clock edge. Its strobe appears one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hub_vld | input | NUM_HUBS | Per-hub match report valid |
| hub_pre | input | NUM_HUBS | Per-hub timing tag: 1 = caught before the defect, 0 = after |
| hub_reach | input | 2*NUM_HUBS | Per-hub reach code: 0 pipeline, 1 module, 2/3 wider |
| hub_cond | input | COND_W*NUM_HUBS | Per-hub condition index |
| act_ack | input | 1 | Acknowledge of the action in flight |
| flush_req | output | 1 | Pipeline flush request strobe |
| modrst_req | output | 1 | Module reset request strobe |
| rollback_req | output | 1 | Checkpoint rollback request strobe |
| osint_req | output | 1 | Operating-system interrupt request strobe |
| cond_off_req | output | 1 | Disable-condition-and-continue strobe to the detectors |
| act_cond | output | COND_W | Condition index of the action in flight |
| act_hub | output | HUB_W | Source hub of the action in flight |
| busy | output | 1 | An action awaits acknowledge |
| hub_full | output | NUM_HUBS | Per-hub holding slot occupied |

## Verification
Each of the following internal faults shows at the ports within a few cycles:
- A wrong classification of a held report surfaces as the wrong strobe two edges after the report.
- A bad arbitration choice surfaces as a wrong `act_hub` or a wrong strobe order within one acknowledge round.
- A lost or overwritten slot shows as a missing or wrong condition index once that hub's turn comes.
- A miscounted timeout moves the escalation strobe away from exactly TIMEOUT cycles after the original strobe, or makes a reset or condition-off escalate.

// File: rtl/rdu_pkg.sv
package rdu_pkg;

    // Action codes ordered by severity: a larger value wins arbitration.
    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_CONT  = 3'd1,
        ACT_FLUSH = 3'd2,
        ACT_MRST  = 3'd3,
        ACT_RBACK = 3'd4,
        ACT_OSINT = 3'd5
    } action_e;

    typedef enum logic [1:0] {
        REACH_PIPE = 2'd0,
        REACH_MOD  = 2'd1,
        REACH_WIDE = 2'd2,
        REACH_FAR  = 2'd3
    } reach_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } disp_state_e;

    // Map the timing tag and the reach of a report onto a recovery action.
    function automatic action_e classify(input logic pre, input logic [1:0] reach);
        action_e a;
        if (pre) begin
            a = (reach == REACH_MOD) ? ACT_MRST : ACT_CONT;
        end else begin
            case (reach)
                REACH_PIPE: a = ACT_FLUSH;
                REACH_MOD:  a = ACT_RBACK;
                default:    a = ACT_OSINT;
            endcase
        end
        return a;
    endfunction

    function automatic logic escalates(input action_e a);
        return (a == ACT_FLUSH) || (a == ACT_RBACK);
    endfunction

endpackage

// File: rtl/rdu_hub_slot.sv
module rdu_hub_slot
    import rdu_pkg::*;
#(
    parameter int COND_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_pre,
    input  logic [1:0]        in_reach,
    input  logic [COND_W-1:0] in_cond,
    input  logic              take,
    output logic              full,
    output action_e           pend_act,
    output logic [COND_W-1:0] pend_cond
);

    // The slot may load when it is empty or when it is being dispatched this cycle.
    logic load;
    assign load = in_vld && (!full || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            full      <= 1'b0;
            pend_act  <= ACT_NONE;
            pend_cond <= '0;
        end else if (load) begin
            full      <= 1'b1;
            pend_act  <= classify(in_pre, in_reach);
            pend_cond <= in_cond;
        end else if (take) begin
            full      <= 1'b0;
            pend_act  <= ACT_NONE;
        end
    end

endmodule

// File: rtl/rdu_arbiter.sv
module rdu_arbiter
    import rdu_pkg::*;
#(
    parameter int NUM_HUBS = 4,
    parameter int COND_W   = 8,
    localparam int HUB_W   = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1
) (
    input  logic [NUM_HUBS-1:0]             full,
    input  logic [NUM_HUBS-1:0][2:0]        acts,
    input  logic [NUM_HUBS-1:0][COND_W-1:0] conds,
    output logic                            win_vld,
    output logic [HUB_W-1:0]                win_idx,
    output action_e                         win_act,
    output logic [COND_W-1:0]               win_cond
);

    // Strictly-greater replacement keeps the lowest index among equals.
    always_comb begin
        win_vld  = 1'b0;
        win_idx  = '0;
        win_act  = ACT_NONE;
        win_cond = '0;
        for (int i = 0; i < NUM_HUBS; i++) begin
            if (full[i] && (acts[i] > win_act)) begin
                win_vld  = 1'b1;
                win_idx  = HUB_W'(i);
                win_act  = action_e'(acts[i]);
                win_cond = conds[i];
            end
        end
    end

endmodule

// File: rtl/rdu_action_fsm.sv
module rdu_action_fsm
    import rdu_pkg::*;
#(
    parameter int NUM_HUBS = 4,
    parameter int COND_W   = 8,
    parameter int TIMEOUT  = 1024,
    localparam int HUB_W   = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1,
    localparam int TW      = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_vld,
    input  action_e           win_act,
    input  logic [COND_W-1:0] win_cond,
    input  logic [HUB_W-1:0]  win_idx,
    input  logic              ack,
    output logic              grant,
    output action_e           pulse,
    output logic              busy,
    output logic [COND_W-1:0] cur_cond,
    output logic [HUB_W-1:0]  cur_hub
);

    localparam logic [TW-1:0] TLIM = TW'(TIMEOUT - 1);

    disp_state_e   st;
    action_e       cur_act;
    logic [TW-1:0] tcnt;

    assign grant = (st == ST_IDLE) && win_vld;
    assign busy  = (st == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_act  <= ACT_NONE;
            cur_cond <= '0;
            cur_hub  <= '0;
            tcnt     <= '0;
            pulse    <= ACT_NONE;
        end else begin
            pulse <= ACT_NONE;
            case (st)
                ST_IDLE: begin
                    if (win_vld) begin
                        st       <= ST_WAIT;
                        cur_act  <= win_act;
                        cur_cond <= win_cond;
                        cur_hub  <= win_idx;
                        pulse    <= win_act;
                        tcnt     <= '0;
                    end
                end
                ST_WAIT: begin
                    if (ack) begin
                        st      <= ST_IDLE;
                        cur_act <= ACT_NONE;
                    end else if (escalates(cur_act) && tcnt == TLIM) begin
                        cur_act <= ACT_OSINT;
                        pulse   <= ACT_OSINT;
                        tcnt    <= '0;
                    end else if (tcnt != TLIM) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/recovery_dispatch.sv
module recovery_dispatch
    import rdu_pkg::*;
#(
    parameter int NUM_HUBS = 4,
    parameter int COND_W   = 8,
    parameter int TIMEOUT  = 1024,
    localparam int HUB_W   = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_HUBS-1:0]          hub_vld,
    input  logic [NUM_HUBS-1:0]          hub_pre,
    input  logic [2*NUM_HUBS-1:0]        hub_reach,
    input  logic [COND_W*NUM_HUBS-1:0]   hub_cond,
    input  logic                         act_ack,
    output logic                         flush_req,
    output logic                         modrst_req,
    output logic                         rollback_req,
    output logic                         osint_req,
    output logic                         cond_off_req,
    output logic [COND_W-1:0]            act_cond,
    output logic [HUB_W-1:0]             act_hub,
    output logic                         busy,
    output logic [NUM_HUBS-1:0]          hub_full
);

    logic [NUM_HUBS-1:0][2:0]        slot_act;
    logic [NUM_HUBS-1:0][COND_W-1:0] slot_cond;
    logic                            win_vld;
    logic [HUB_W-1:0]                win_idx;
    action_e                         win_act;
    logic [COND_W-1:0]               win_cond;
    logic                            grant;
    action_e                         pulse;

    for (genvar g = 0; g < NUM_HUBS; g++) begin : g_slot
        action_e s_act;
        rdu_hub_slot #(.COND_W(COND_W)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .in_vld   (hub_vld[g]),
            .in_pre   (hub_pre[g]),
            .in_reach (hub_reach[2*g +: 2]),
            .in_cond  (hub_cond[COND_W*g +: COND_W]),
            .take     (grant && (win_idx == HUB_W'(g))),
            .full     (hub_full[g]),
            .pend_act (s_act),
            .pend_cond(slot_cond[g])
        );
        assign slot_act[g] = s_act;
    end

    rdu_arbiter #(.NUM_HUBS(NUM_HUBS), .COND_W(COND_W)) u_arb (
        .full    (hub_full),
        .acts    (slot_act),
        .conds   (slot_cond),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_act (win_act),
        .win_cond(win_cond)
    );

    rdu_action_fsm #(.NUM_HUBS(NUM_HUBS), .COND_W(COND_W), .TIMEOUT(TIMEOUT)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .win_vld (win_vld),
        .win_act (win_act),
        .win_cond(win_cond),
        .win_idx (win_idx),
        .ack     (act_ack),
        .grant   (grant),
        .pulse   (pulse),
        .busy    (busy),
        .cur_cond(act_cond),
        .cur_hub (act_hub)
    );

    assign flush_req    = (pulse == ACT_FLUSH);
    assign modrst_req   = (pulse == ACT_MRST);
    assign rollback_req = (pulse == ACT_RBACK);
    assign osint_req    = (pulse == ACT_OSINT);
    assign cond_off_req = (pulse == ACT_CONT);

endmodule

// File: rtl/rdu_checker.sv
module rdu_checker #(
    parameter int NUM_HUBS = 4,
    parameter int COND_W   = 8,
    parameter int HUB_W    = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                flush_req,
    input logic                modrst_req,
    input logic                rollback_req,
    input logic                osint_req,
    input logic                cond_off_req,
    input logic                act_ack,
    input logic                busy,
    input logic [COND_W-1:0]   act_cond,
    input logic [HUB_W-1:0]    act_hub,
    input logic [NUM_HUBS-1:0] hub_full
);

    logic [4:0] strobes;
    assign strobes = {flush_req, modrst_req, rollback_req, osint_req, cond_off_req};

    // R6
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes));

    // R6
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (|strobes) |=> !(|strobes));

    // R6
    action_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !act_ack) |=> ($stable(act_cond) && $stable(act_hub)));

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !act_ack) |=> busy);

    // R7
    no_new_action_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !act_ack) |=> !(flush_req || modrst_req || rollback_req || cond_off_req));

    // R7
    strobe_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (|strobes) |-> busy);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!busy && hub_full == '0 && !(|strobes)));

endmodule

bind recovery_dispatch rdu_checker #(
    .NUM_HUBS(NUM_HUBS),
    .COND_W  (COND_W),
    .HUB_W   (HUB_W)
) u_rdu_chk (
    .clk         (clk),
    .rst         (rst),
    .flush_req   (flush_req),
    .modrst_req  (modrst_req),
    .rollback_req(rollback_req),
    .osint_req   (osint_req),
    .cond_off_req(cond_off_req),
    .act_ack     (act_ack),
    .busy        (busy),
    .act_cond    (act_cond),
    .act_hub     (act_hub),
    .hub_full    (hub_full)
);

// File: tb/test_recovery_dispatch.sv
module test_recovery_dispatch;

    localparam int N  = 4;
    localparam int CW = 6;
    localparam int T  = 8;
    localparam int HW = 2;

    // bench action codes: 0 cond-off, 1 flush, 2 module reset, 3 rollback, 4 os interrupt
    typedef struct {
        int act;
        int cond;
        int hub;
        string req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    hub_vld = '0;
    logic [N-1:0]    hub_pre = '0;
    logic [2*N-1:0]  hub_reach = '0;
    logic [CW*N-1:0] hub_cond = '0;
    logic            act_ack = 1'b0;
    logic            flush_req, modrst_req, rollback_req, osint_req, cond_off_req;
    logic [CW-1:0]   act_cond;
    logic [HW-1:0]   act_hub;
    logic            busy;
    logic [N-1:0]    hub_full;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    recovery_dispatch #(.NUM_HUBS(N), .COND_W(CW), .TIMEOUT(T)) i_recovery_dispatch (
        .clk(clk), .rst(rst), .hub_vld(hub_vld), .hub_pre(hub_pre),
        .hub_reach(hub_reach), .hub_cond(hub_cond), .act_ack(act_ack),
        .flush_req(flush_req), .modrst_req(modrst_req), .rollback_req(rollback_req),
        .osint_req(osint_req), .cond_off_req(cond_off_req), .act_cond(act_cond),
        .act_hub(act_hub), .busy(busy), .hub_full(hub_full)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_act(input bit pre, input int reach);
        if (pre) return (reach == 1) ? 2 : 0;
        if (reach == 0) return 1;
        if (reach == 1) return 3;
        return 4;
    endfunction

    task automatic push(input int act, input int cond, input int hub, input string req);
        exp_t e;
        e.act = act; e.cond = cond; e.hub = hub; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compares each issued strobe against the scoreboard head.
    always @(negedge clk) begin
        if (!rst) begin
            int n;
            int obs;
            n = int'(flush_req) + int'(modrst_req) + int'(rollback_req) + int'(osint_req) + int'(cond_off_req);
            obs = cond_off_req ? 0 : flush_req ? 1 : modrst_req ? 2 : rollback_req ? 3 : osint_req ? 4 : -1;
            if (n > 1) check(0, "R6 strobe count", n, 1);
            if (n > 0) begin
                if (q.size() == 0) begin
                    check(0, "R7 unexpected strobe", obs, -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(obs == e.act, e.req, obs, e.act);
                    check(int'(act_cond) == e.cond, {e.req, " cond"}, int'(act_cond), e.cond);
                    check(int'(act_hub) == e.hub, {e.req, " hub"}, int'(act_hub), e.hub);
                end
            end
        end
    end

    // Driver: offers one report on one hub for one cycle and records the expected action.
    task automatic offer(input int h, input bit pre, input int reach, input int cond,
                         input bit expect_it, input string req);
        hub_vld[h]              = 1'b1;
        hub_pre[h]              = pre;
        hub_reach[2*h +: 2]     = 2'(reach);
        hub_cond[CW*h +: CW]    = CW'(cond);
        if (expect_it) push(model_act(pre, reach), cond, h, req);
        @(negedge clk);
        hub_vld = '0;
    endtask

    // Wait for the next scoreboard pop, then acknowledge.
    task automatic serve_one();
        int s;
        s = q.size();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            #1;
            if (q.size() < s) break;
        end
        act_ack = 1'b1;
        @(negedge clk);
        act_ack = 1'b0;
    endtask

    initial begin
        #800000;
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(busy == 1'b0, "R10 busy", busy, 0);
        check(hub_full == '0, "R10 hub_full", hub_full, 0);
        check({flush_req, modrst_req, rollback_req, osint_req, cond_off_req} == '0, "R10 strobes", 1, 0);

        // R11 latency and R1 mapping
        offer(2, 1'b0, 0, 5, 1'b1, "R1 flush");
        check(hub_full[2] == 1'b1, "R11 latched", hub_full[2], 1);
        check(!flush_req, "R11 no early strobe", flush_req, 0);
        @(negedge clk);
        check(busy == 1'b1, "R7 busy after strobe", busy, 1);
        check(hub_full[2] == 1'b0, "R8 slot drained", hub_full[2], 0);
        act_ack = 1'b1; @(negedge clk); act_ack = 1'b0;
        check(busy == 1'b0, "R7 idle after ack", busy, 0);

        // R2, R3, R4 mappings
        offer(1, 1'b0, 1, 7, 1'b1, "R2 rollback");  serve_one();
        offer(3, 1'b0, 2, 8, 1'b1, "R3 osint reach2");  serve_one();
        offer(0, 1'b0, 3, 9, 1'b1, "R3 osint reach3");  serve_one();
        offer(2, 1'b1, 1, 10, 1'b1, "R4 module reset");  serve_one();
        offer(1, 1'b1, 0, 11, 1'b1, "R4 cond-off pipe");  serve_one();
        offer(3, 1'b1, 3, 12, 1'b1, "R4 cond-off wide");  serve_one();

        // R5 arbitration: four hubs at once
        hub_vld = '1;
        hub_pre   = 4'b0001;
        hub_reach = {2'd1, 2'd0, 2'd1, 2'd0};
        hub_cond  = {6'd13, 6'd12, 6'd11, 6'd10};
        push(3, 11, 1, "R5 rollback low hub");
        push(3, 13, 3, "R5 rollback next");
        push(1, 12, 2, "R5 flush");
        push(0, 10, 0, "R5 cond-off last");
        @(negedge clk);
        hub_vld = '0;
        check(hub_full == 4'hF, "R8 all slots held", hub_full, 15);
        repeat (4) serve_one();

        // R8 held while busy, second report to a full slot discarded
        offer(0, 1'b1, 2, 20, 1'b1, "R8 first action");
        @(negedge clk);
        offer(2, 1'b0, 1, 21, 1'b1, "R8 held report");
        offer(2, 1'b0, 3, 22, 1'b0, "R8 discarded");
        check(hub_full[2] == 1'b1, "R8 slot full while busy", hub_full[2], 1);
        check(busy == 1'b1, "R7 still busy", busy, 1);
        act_ack = 1'b1; @(negedge clk); act_ack = 1'b0;
        serve_one();
        repeat (6) @(negedge clk);
        check(hub_full == '0, "R8 nothing left", hub_full, 0);
        check(busy == 1'b0, "R8 no extra action", busy, 0);

        // R9 escalation of an unacknowledged flush after T cycles
        offer(1, 1'b0, 0, 30, 1'b1, "R9 flush");
        push(4, 30, 1, "R9 escalated osint");
        @(negedge clk);
        check(flush_req == 1'b1, "R9 flush strobe", flush_req, 1);
        repeat (T - 1) @(negedge clk);
        check(osint_req == 1'b0, "R9 not early", osint_req, 0);
        @(negedge clk);
        check(osint_req == 1'b1, "R9 osint at timeout", osint_req, 1);
        act_ack = 1'b1; @(negedge clk); act_ack = 1'b0;

        // R9 rollback escalates too
        offer(3, 1'b0, 1, 31, 1'b1, "R9 rollback");
        push(4, 31, 3, "R9 rollback escalated");
        repeat (T + 2) @(negedge clk);
        act_ack = 1'b1; @(negedge clk); act_ack = 1'b0;

        // R9 module reset never escalates
        offer(2, 1'b1, 1, 32, 1'b1, "R9 module reset");
        repeat (3 * T) @(negedge clk);
        check(busy == 1'b1, "R9 reset waits without escalation", busy, 1);
        act_ack = 1'b1; @(negedge clk); act_ack = 1'b0;

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R7 scoreboard drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule